// File: doc/BRIEF.md
# Command-Address Parity Checker

This block sits at the command input of a memory device and screens every selected command word before it is allowed to run. Each word consists of the activate bit, the row-strobe, column-strobe and write-enable bits, the address bus, and the bank and bank-group bits. The block XORs these bits with a parity input. After a programmable delay it issues an execute or block decision for that command. The delay models the time needed inside the device to compute the parity.

A sticky error flag records that a parity failure was seen. It stays set until a clear pulse arrives; that pulse stands for a mode-register write. A configuration bit decides what happens while the flag is set. In the default mode, checking is suspended and every command passes. In persistent mode, checking goes on and failing commands are still refused. A one-cycle pulse marks each individual failure so that failures can be counted. The latency selection and the persistent bit are assumed to be static while commands are in flight.

Top module: `ca_parity_gate`

## Requirements
- R1: After reset, `err_status`, `exe_vld`, `exe_go` and `err_pulse` are all 0, and checking is off while `cfg_lat_sel` is 0.
- R2: Parity is even over the activate, row-strobe, column-strobe and write-enable bits, every `addr` bit, every `bank` bit and every `bgrp` bit together with `par_in`. A command passes only when that XOR is 0. A single flipped bit in any of these inputs makes it fail.
- R3: `cke_in` and `odt_in` have no influence on the parity result or on any output.
- R4: A command is taken only in a cycle where both `cmd_vld` and `cmd_sel` are 1. Any other cycle gives no decision and never raises an error, whatever its parity.
- R5: The `cfg_lat_sel` codes are 1 = 4 cycles, 2 = 5, 3 = 6 and 4 = 8. Any of these codes enables checking. `exe_vld` is 1 for exactly one cycle, exactly that many cycles after the cycle in which the command was taken, and is 0 in the cycle before.
- R6: The codes 0, 5, 6 and 7 disable checking. In that case the decision appears one cycle after the command with `exe_go` = 1 and no error, even when parity is wrong.
- R7: When checking is active and a command fails, its decision cycle shows `exe_vld` = 1, `exe_go` = 0 and `err_pulse` = 1.
- R8: `err_status` becomes 1 in the cycle after `err_pulse`. It stays 1 until a clear.
- R9: When `cfg_persist` is 0 and `err_status` is 1, failing commands are not checked. They get `exe_go` = 1 with no `err_pulse`.
- R10: When `cfg_persist` is 1 and `err_status` is 1, failing commands still get `exe_go` = 0 and `err_pulse` = 1.
- R11: If `clr_status` and `err_pulse` are both 1 in the same cycle, `err_status` is 1 in the next cycle.
- R12: A `clr_status` pulse with no coincident failure makes `err_status` 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Command word present this cycle |
| cmd_sel | input | 1 | Device selected (active high); not covered by parity |
| cmd_act | input | 1 | Activate command bit |
| cmd_ras | input | 1 | Row-strobe / multiplexed address bit |
| cmd_cas | input | 1 | Column-strobe / multiplexed address bit |
| cmd_we | input | 1 | Write-enable / multiplexed address bit |
| addr | input | ADDR_W | Address bus |
| bank | input | BA_W | Bank address |
| bgrp | input | BG_W | Bank group |
| par_in | input | 1 | Even parity bit for the command word |
| cke_in | input | 1 | Clock-enable; excluded from parity |
| odt_in | input | 1 | Termination control; excluded from parity |
| cfg_lat_sel | input | 3 | Latency code: 0 off, 1..4 select 4/5/6/8 cycles |
| cfg_persist | input | 1 | 1 = keep checking while the error flag is set |
| clr_status | input | 1 | Clear pulse for the error flag |
| exe_vld | output | 1 | A decision is presented this cycle |
| exe_go | output | 1 | 1 = execute, 0 = block |
| err_pulse | output | 1 | One-cycle marker of a failing checked command |
| err_status | output | 1 | Sticky parity error flag |

## Verification
The timing is counted from the cycle in which the command is driven. With checking enabled, the decision and `err_pulse` are due exactly L cycles later, where L is 4, 5, 6 or 8. With checking off, they are due one cycle later. `err_status` follows one cycle after the pulse, and a clear acts one cycle after the pulse on `clr_status`. Every input change and every sample in the bench happens one time unit after a rising edge, and the bench advances a counted number of edges before each sample. For each latency it also checks that `exe_vld` is still low one cycle before it is due, so an early decision fails just as a late one does.

// File: rtl/ca_parity_pkg.sv
package ca_parity_pkg;

    localparam int unsigned LAT_SEL_W = 3;

    typedef struct packed {
        logic vld;
        logic bad;
    } pipe_ent_t;

    typedef struct packed {
        logic err;
    } stat_t;

endpackage

// File: rtl/ca_parity_tree.sv
module ca_parity_tree #(
    parameter int unsigned IN_W = 8
) (
    input  logic [IN_W-1:0] bits_in,
    input  logic            par_in,
    output logic            bad
);
    always_comb begin
        bad = par_in;
        for (int i = 0; i < IN_W; i++) begin
            bad = bad ^ bits_in[i];
        end
    end
endmodule

// File: rtl/ca_parity_lat_dec.sv
module ca_parity_lat_dec
    import ca_parity_pkg::*;
#(
    parameter int unsigned MAX_LAT = 8,
    localparam int unsigned IDX_W  = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1
) (
    input  logic [LAT_SEL_W-1:0] sel,
    output logic                 chk_en,
    output logic [IDX_W-1:0]     tap_idx
);
    always_comb begin
        chk_en  = 1'b1;
        tap_idx = IDX_W'(0);
        case (sel)
            3'd1:    tap_idx = IDX_W'(3);
            3'd2:    tap_idx = IDX_W'(4);
            3'd3:    tap_idx = IDX_W'(5);
            3'd4:    tap_idx = IDX_W'(7);
            default: chk_en  = 1'b0;
        endcase
    end
endmodule

// File: rtl/ca_parity_pipe.sv
module ca_parity_pipe
    import ca_parity_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pipe_ent_t        ent_in,
    input  logic [IDX_W-1:0] tap_idx,
    output pipe_ent_t        ent_out
);
    pipe_ent_t [DEPTH-1:0] stg_d, stg_q;

    generate
        if (DEPTH > 1) begin : g_multi
            always_comb begin
                stg_d = {stg_q[DEPTH-2:0], ent_in};
            end
        end else begin : g_single
            always_comb begin
                stg_d = ent_in;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    always_comb begin
        ent_out = stg_q[tap_idx];
    end
endmodule

// File: rtl/ca_parity_gate.sv
module ca_parity_gate
    import ca_parity_pkg::*;
#(
    parameter int unsigned ADDR_W  = 17,
    parameter int unsigned BA_W    = 2,
    parameter int unsigned BG_W    = 2,
    parameter int unsigned MAX_LAT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_vld,
    input  logic                 cmd_sel,
    input  logic                 cmd_act,
    input  logic                 cmd_ras,
    input  logic                 cmd_cas,
    input  logic                 cmd_we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BA_W-1:0]      bank,
    input  logic [BG_W-1:0]      bgrp,
    input  logic                 par_in,
    input  logic                 cke_in,
    input  logic                 odt_in,
    input  logic [LAT_SEL_W-1:0] cfg_lat_sel,
    input  logic                 cfg_persist,
    input  logic                 clr_status,
    output logic                 exe_vld,
    output logic                 exe_go,
    output logic                 err_pulse,
    output logic                 err_status
);
    localparam int unsigned COV_W = 4 + ADDR_W + BA_W + BG_W;
    localparam int unsigned IDX_W = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1;

    // side-band pins are deliberately excluded from the parity word
    logic unused_side;
    assign unused_side = cke_in ^ odt_in;

    logic [COV_W-1:0] cov_bits;
    logic             word_bad;
    logic             chk_en;
    logic [IDX_W-1:0] tap_idx;
    pipe_ent_t        ent_in, ent_out;
    stat_t            st_d, st_q;
    logic             chk_live;
    logic             blk;

    assign cov_bits = {cmd_act, cmd_ras, cmd_cas, cmd_we, addr, bank, bgrp};

    ca_parity_tree #(.IN_W(COV_W)) u_tree (
        .bits_in (cov_bits),
        .par_in  (par_in),
        .bad     (word_bad)
    );

    ca_parity_lat_dec #(.MAX_LAT(MAX_LAT)) u_dec (
        .sel     (cfg_lat_sel),
        .chk_en  (chk_en),
        .tap_idx (tap_idx)
    );

    always_comb begin
        ent_in.vld = cmd_vld & cmd_sel;
        ent_in.bad = word_bad;
    end

    ca_parity_pipe #(.DEPTH(MAX_LAT)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .ent_in  (ent_in),
        .tap_idx (tap_idx),
        .ent_out (ent_out)
    );

    always_comb begin
        chk_live = chk_en & (cfg_persist | ~st_q.err);
        blk      = ent_out.vld & chk_live & ent_out.bad;
        st_d     = st_q;
        if (blk) begin
            st_d.err = 1'b1;
        end else if (clr_status) begin
            st_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign exe_vld    = ent_out.vld;
    assign exe_go     = ent_out.vld & ~blk;
    assign err_pulse  = blk;
    assign err_status = st_q.err;
endmodule

// File: rtl/ca_parity_gate_chk.sv
module ca_parity_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cfg_lat_sel,
    input logic       cfg_persist,
    input logic       clr_status,
    input logic       exe_vld,
    input logic       exe_go,
    input logic       err_pulse,
    input logic       err_status
);
    AST_PULSE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (exe_vld && !exe_go)); // R7
    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> err_status); // R8
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_status && !clr_status) |=> err_status); // R8
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && !err_pulse) |=> !err_status); // R12
    AST_ERROR_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && err_pulse) |=> err_status); // R11
    AST_NONPERSIST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (err_status && !cfg_persist) |-> !err_pulse); // R9
    AST_DISABLED_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lat_sel == 3'd0 || cfg_lat_sel > 3'd4) |-> !err_pulse); // R6
    AST_GO_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        exe_go |-> exe_vld); // R4
endmodule

bind ca_parity_gate ca_parity_gate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_lat_sel (cfg_lat_sel),
    .cfg_persist (cfg_persist),
    .clr_status  (clr_status),
    .exe_vld     (exe_vld),
    .exe_go      (exe_go),
    .err_pulse   (err_pulse),
    .err_status  (err_status)
);

// File: tb/ca_parity_gate_bench.sv
module ca_parity_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 17;
    localparam int BA_W = 2;
    localparam int BG_W = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic cmd_vld, cmd_sel, cmd_act, cmd_ras, cmd_cas, cmd_we;
    logic [ADDR_W-1:0] addr;
    logic [BA_W-1:0] bank;
    logic [BG_W-1:0] bgrp;
    logic par_in, cke_in, odt_in;
    logic [2:0] cfg_lat_sel;
    logic cfg_persist, clr_status;
    logic exe_vld, exe_go, err_pulse, err_status;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ca_parity_gate u_ca_parity_gate (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_sel(cmd_sel),
        .cmd_act(cmd_act), .cmd_ras(cmd_ras), .cmd_cas(cmd_cas), .cmd_we(cmd_we),
        .addr(addr), .bank(bank), .bgrp(bgrp), .par_in(par_in),
        .cke_in(cke_in), .odt_in(odt_in), .cfg_lat_sel(cfg_lat_sel),
        .cfg_persist(cfg_persist), .clr_status(clr_status),
        .exe_vld(exe_vld), .exe_go(exe_go), .err_pulse(err_pulse),
        .err_status(err_status)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one command for one cycle; corrupt=1 breaks even parity.
    // Optionally flip one covered bit after computing parity (grp 0..6).
    task automatic send(input logic sel, input logic corrupt, input int grp,
                        input logic [ADDR_W-1:0] a, input logic [3:0] cmd);
        logic p;
        cmd_act = cmd[3]; cmd_ras = cmd[2]; cmd_cas = cmd[1]; cmd_we = cmd[0];
        addr = a; bank = a[1:0]; bgrp = a[3:2];
        p = ^{cmd_act, cmd_ras, cmd_cas, cmd_we, addr, bank, bgrp};
        par_in = p ^ corrupt;
        case (grp)
            0: cmd_act = ~cmd_act;
            1: cmd_ras = ~cmd_ras;
            2: cmd_cas = ~cmd_cas;
            3: cmd_we  = ~cmd_we;
            4: addr[ADDR_W-1] = ~addr[ADDR_W-1];
            5: bank[BA_W-1] = ~bank[BA_W-1];
            6: bgrp[0] = ~bgrp[0];
            default: ;
        endcase
        cmd_vld = 1'b1;
        cmd_sel = sel;
        tick();
        cmd_vld = 1'b0;
        cmd_sel = 1'b0;
        par_in = 1'b0;
    endtask

    task automatic do_clear();
        clr_status = 1'b1;
        tick();
        clr_status = 1'b0;
        chk("R12 flag cleared", err_status, 0);
    endtask

    task automatic t_reset();
        chk("R1 status", err_status, 0);
        chk("R1 exe_vld", exe_vld, 0);
        chk("R1 exe_go", exe_go, 0);
        chk("R1 err_pulse", err_pulse, 0);
    endtask

    task automatic t_latency(input logic [2:0] code, input int lat);
        cfg_lat_sel = code;
        send(1'b1, 1'b0, -1, 17'h0A5C3, 4'b1010);
        wait_cyc(lat - 2);
        chk($sformatf("R5 early lat %0d", lat), exe_vld, 0);
        tick();
        chk($sformatf("R5 due lat %0d", lat), exe_vld, 1);
        chk($sformatf("R5 go lat %0d", lat), exe_go, 1);
        tick();
        chk($sformatf("R5 single lat %0d", lat), exe_vld, 0);
    endtask

    task automatic t_disabled();
        for (int c = 0; c < 8; c = c + 5) begin
            cfg_lat_sel = 3'(c);
            send(1'b1, 1'b1, -1, 17'h1F00F, 4'b0110);
            chk("R6 decision after one cycle", exe_vld, 1);
            chk("R6 go despite bad parity", exe_go, 1);
            chk("R6 no pulse", err_pulse, 0);
            tick();
            chk("R6 status untouched", err_status, 0);
        end
    endtask

    task automatic t_coverage();
        cfg_lat_sel = 3'd1;
        cfg_persist = 1'b1;
        for (int g = 0; g < 7; g++) begin
            send(1'b1, 1'b0, g, 17'h05A5A ^ 17'(g * 97), 4'(g));
            wait_cyc(3);
            chk($sformatf("R2 flip group %0d blocked", g), exe_go, 0);
            chk($sformatf("R7 pulse group %0d", g), err_pulse, 1);
            chk($sformatf("R7 vld group %0d", g), exe_vld, 1);
        end
        tick();
        chk("R8 flag set", err_status, 1);
        do_clear();
        for (int k = 0; k < 3; k++) begin
            send(1'b1, 1'b0, -1, 17'(k * 12345 + 7), 4'(k * 5));
            wait_cyc(3);
            chk($sformatf("R2 good pattern %0d", k), exe_go, 1);
            chk($sformatf("R2 good no pulse %0d", k), err_pulse, 0);
        end
        cfg_persist = 1'b0;
    endtask

    task automatic t_side();
        cfg_lat_sel = 3'd1;
        for (int k = 0; k < 4; k++) begin
            cke_in = k[0];
            odt_in = k[1];
            send(1'b1, 1'b0, -1, 17'h12345, 4'b1111);
            wait_cyc(3);
            chk($sformatf("R3 go with side %0d", k), exe_go, 1);
        end
        cke_in = 1'b1;
        odt_in = 1'b0;
        chk("R3 status", err_status, 0);
    endtask

    task automatic t_deselect();
        bit seen;
        cfg_lat_sel = 3'd1;
        seen = 0;
        send(1'b0, 1'b1, -1, 17'h00FFF, 4'b0001);
        for (int i = 0; i < 6; i++) begin
            if (exe_vld || err_pulse) seen = 1;
            tick();
        end
        chk("R4 deselect silent", int'(seen), 0);
        chk("R4 no flag", err_status, 0);
    endtask

    task automatic t_sticky();
        cfg_lat_sel = 3'd2;
        cfg_persist = 1'b0;
        send(1'b1, 1'b1, -1, 17'h0BEEF, 4'b1000);
        wait_cyc(4);
        chk("R7 blocked", exe_go, 0);
        tick();
        chk("R8 set", err_status, 1);
        wait_cyc(5);
        chk("R8 holds", err_status, 1);
        send(1'b1, 1'b1, -1, 17'h00123, 4'b0100);
        wait_cyc(4);
        chk("R9 unchecked go", exe_go, 1);
        chk("R9 no pulse", err_pulse, 0);
        do_clear();
    endtask

    task automatic t_persist();
        cfg_lat_sel = 3'd3;
        cfg_persist = 1'b1;
        send(1'b1, 1'b1, -1, 17'h00777, 4'b0011);
        wait_cyc(6);
        tick();
        chk("R8 set persist", err_status, 1);
        send(1'b1, 1'b1, -1, 17'h10001, 4'b1100);
        wait_cyc(5);
        chk("R10 still blocked", exe_go, 0);
        chk("R10 still pulses", err_pulse, 1);
        send(1'b1, 1'b0, -1, 17'h10001, 4'b1100);
        wait_cyc(5);
        chk("R10 good passes", exe_go, 1);
        do_clear();
        cfg_persist = 1'b0;
    endtask

    task automatic t_collide();
        cfg_lat_sel = 3'd4;
        send(1'b1, 1'b1, -1, 17'h0CAFE, 4'b0101);
        wait_cyc(7);
        chk("R11 pulse present", err_pulse, 1);
        clr_status = 1'b1;
        tick();
        clr_status = 1'b0;
        chk("R11 error wins", err_status, 1);
        do_clear();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        cmd_vld = 0; cmd_sel = 0; cmd_act = 0; cmd_ras = 0; cmd_cas = 0; cmd_we = 0;
        addr = '0; bank = '0; bgrp = '0; par_in = 0; cke_in = 0; odt_in = 0;
        cfg_lat_sel = 3'd0; cfg_persist = 0; clr_status = 0;
        wait_cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_latency(3'd1, 4);
        t_latency(3'd2, 5);
        t_latency(3'd3, 6);
        t_latency(3'd4, 8);
        t_disabled();
        t_coverage();
        t_side();
        t_deselect();
        t_sticky();
        t_persist();
        t_collide();
        finish_run();
    end
endmodule